// File: doc/BRIEF.md
# Operand Shifter with Carry-Out

This block is the operand shifter of a small processor datapath. It takes one data word, a 3-bit code that selects the kind of shift, a shift amount and the current carry flag. It returns the shifted word and the carry produced by the shifter. Five kinds of shift are supported: logical left, logical right, arithmetic right, rotate right, and a one-bit extended rotate right that passes through the carry. The amount can come either from an immediate field or from a register. Only its low byte counts, so a wide register value can be connected directly.

The carry-out depends on the shift kind. Amounts of zero, of exactly the word width and of more than the word width each have their own rule. Code values that do not select a supported kind pass the word and the carry through unchanged and raise an error flag. An optional output register stage, chosen by a parameter, adds one clock of latency to meet timing. Reset clears that stage.

Top module: `opsh_shifter`

## Requirements
- R1: Code 0 (logical left) by an amount n from 1 to 32 gives the data shifted left by n with zeros filled in. The carry-out is input bit 32−n, so n = 32 gives a zero result and a carry-out of input bit 0.
- R2: Code 0 with an amount above 32 gives a result of zero and a carry-out of 0.
- R3: For codes 0 to 3, an amount of zero returns the data unchanged, and the carry-out equals the incoming carry.
- R4: Code 1 (logical right) by n from 1 to 32 gives the data shifted right with zeros filled in. The carry-out is input bit n−1.
- R5: Code 1 with an amount above 32 gives a result of zero and a carry-out of 0.
- R6: Code 2 (arithmetic right) by n from 1 to 32 fills the vacated bits with input bit 31, and the carry-out is input bit n−1. At n = 32 the result is 32 copies of bit 31, and the carry-out is bit 31.
- R7: Code 2 with an amount above 32 gives 32 copies of input bit 31 and a carry-out equal to bit 31.
- R8: Code 3 (rotate right) rotates by the amount modulo 32, and the carry-out is bit 31 of the result. A nonzero amount that is a multiple of 32 returns the data unchanged with a carry-out of input bit 31.
- R9: Code 4 (extended rotate) ignores the amount. The result is the data shifted right by one with the incoming carry placed in bit 31, and the carry-out is input bit 0.
- R10: Only bits 7:0 of the amount input are used. Bits 31:8 have no effect on the result or the carry-out.
- R11: Codes 5, 6 and 7 return the data unchanged, pass the incoming carry through and set the error flag. For codes 0 to 4 the error flag is 0.
- R12: With the output stage enabled (the default), the outputs follow the inputs one clock later. While reset is asserted the result, the carry-out and the error flag are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| data_in | input | 32 | Word to be shifted |
| kind_in | input | 3 | Shift kind code (0 to 4 valid) |
| amount_in | input | 32 | Shift amount; only bits 7:0 are used |
| carry_in | input | 1 | Incoming carry flag |
| data_out | output | 32 | Shifted word |
| carry_out | output | 1 | Shifter carry-out |
| kind_err | output | 1 | Set when the kind code is 5, 6 or 7 |

## Verification
Each shift kind is run over every amount from 0 to 40 and over 255, on data words with sparse, dense, alternating, sign-set and sign-clear bit patterns. This shows whether the carry comes from the correct bit and whether the fill is zero or the sign bit. Both values of the incoming carry are used, so that the zero-amount and extended-rotate paths show whether the carry is really passed through. The same low byte is tried with different values in the upper amount bits to show that those bits are ignored. The three unused codes are checked with both carry values.

// File: rtl/opsh_pkg.sv
package opsh_pkg;

   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;

   localparam int unsigned KIND_W = 3;

endpackage

// File: rtl/opsh_amount.sv
module opsh_amount #(
   parameter int unsigned AMT_IN_W = 32,
   parameter int unsigned SHAMT_W  = 8,
   parameter int unsigned LOGW     = 5
) (
   input  logic [AMT_IN_W-1:0] amt_raw,
   output logic [SHAMT_W-1:0]  amt_used,
   output logic                amt_is_zero,
   output logic [LOGW-1:0]     amt_mod
);
   // Upper amount bits are dropped here, so nothing downstream sees them.
   assign amt_used    = amt_raw[SHAMT_W-1:0];
   assign amt_is_zero = (amt_used == '0);
   assign amt_mod     = amt_used[LOGW-1:0];
endmodule

// File: rtl/opsh_core.sv
module opsh_core
   import opsh_pkg::*;
#(
   parameter int unsigned WIDTH   = 32,
   parameter int unsigned SHAMT_W = 8,
   parameter int unsigned LOGW    = 5
) (
   input  logic [WIDTH-1:0]   src,
   input  logic [KIND_W-1:0]  kind,
   input  logic [SHAMT_W-1:0] amt,
   input  logic               amt_zero,
   input  logic [LOGW-1:0]    amt_mod,
   input  logic               cin,
   output logic [WIDTH-1:0]   res,
   output logic               cout,
   output logic               err
);
   // Each shift runs on a word one bit wider than the data. The extra bit
   // catches the last bit shifted out, so no separate carry mux is needed.
   logic [WIDTH:0]        lsl_ext;
   logic [WIDTH:0]        lsr_ext;
   logic signed [WIDTH:0] asr_ext;
   logic [WIDTH-1:0]      ror_val;
   logic [LOGW:0]         ror_back;

   always_comb begin
      lsl_ext  = {1'b0, src} << amt;
      lsr_ext  = {src, 1'b0} >> amt;
      asr_ext  = $signed({src, 1'b0}) >>> amt;
      ror_back = (LOGW+1)'(WIDTH) - (LOGW+1)'(amt_mod);
      ror_val  = (src >> amt_mod) | (src << ror_back);
   end

   always_comb begin
      res  = src;
      cout = cin;
      err  = 1'b0;
      case (kind)
         SK_LSL: if (!amt_zero) begin
            res  = lsl_ext[WIDTH-1:0];
            cout = lsl_ext[WIDTH];
         end
         SK_LSR: if (!amt_zero) begin
            res  = lsr_ext[WIDTH:1];
            cout = lsr_ext[0];
         end
         SK_ASR: if (!amt_zero) begin
            res  = asr_ext[WIDTH:1];
            cout = asr_ext[0];
         end
         SK_ROR: if (!amt_zero) begin
            res  = ror_val;
            cout = ror_val[WIDTH-1];
         end
         SK_RRX: begin
            res  = {cin, src[WIDTH-1:1]};
            cout = src[0];
         end
         default: err = 1'b1;
      endcase
   end
endmodule

// File: rtl/opsh_outstage.sv
module opsh_outstage #(
   parameter int unsigned WIDTH   = 32,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] res_d,
   input  logic             cout_d,
   input  logic             err_d,
   output logic [WIDTH-1:0] res_q,
   output logic             cout_q,
   output logic             err_q
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               res_q  <= '0;
               cout_q <= 1'b0;
               err_q  <= 1'b0;
            end else begin
               res_q  <= res_d;
               cout_q <= cout_d;
               err_q  <= err_d;
            end
         end

         p_out_stage_r12: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (res_q == $past(res_d)) && (cout_q == $past(cout_d))
                     && (err_q == $past(err_d)));
      end else begin : g_comb
         assign res_q  = res_d;
         assign cout_q = cout_d;
         assign err_q  = err_d;
      end
   endgenerate
endmodule

// File: rtl/opsh_shifter.sv
module opsh_shifter
   import opsh_pkg::*;
#(
   parameter int unsigned WIDTH    = 32,
   parameter int unsigned AMT_IN_W = 32,
   parameter int unsigned SHAMT_W  = 8,
   parameter bit          OUT_REG  = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [WIDTH-1:0]    data_in,
   input  logic [KIND_W-1:0]   kind_in,
   input  logic [AMT_IN_W-1:0] amount_in,
   input  logic                carry_in,
   output logic [WIDTH-1:0]    data_out,
   output logic                carry_out,
   output logic                kind_err
);
   localparam int unsigned LOGW = $clog2(WIDTH);

   generate
      if (WIDTH < 2 || (WIDTH & (WIDTH - 1)) != 0) begin : g_bad_width
         $fatal(1, "opsh_shifter: WIDTH must be a power of two of at least 2");
      end
      if (AMT_IN_W < SHAMT_W) begin : g_bad_amt
         $fatal(1, "opsh_shifter: AMT_IN_W narrower than SHAMT_W");
      end
      if ((1 << SHAMT_W) <= WIDTH) begin : g_bad_shamt
         $fatal(1, "opsh_shifter: SHAMT_W cannot express WIDTH");
      end
   endgenerate

   logic [SHAMT_W-1:0] amt_used;
   logic               amt_zero;
   logic [LOGW-1:0]    amt_mod;
   logic [WIDTH-1:0]   core_res;
   logic               core_cout;
   logic               core_err;

   opsh_amount #(.AMT_IN_W(AMT_IN_W), .SHAMT_W(SHAMT_W), .LOGW(LOGW)) u_amount (
      .amt_raw     (amount_in),
      .amt_used    (amt_used),
      .amt_is_zero (amt_zero),
      .amt_mod     (amt_mod)
   );

   opsh_core #(.WIDTH(WIDTH), .SHAMT_W(SHAMT_W), .LOGW(LOGW)) u_core (
      .src      (data_in),
      .kind     (kind_in),
      .amt      (amt_used),
      .amt_zero (amt_zero),
      .amt_mod  (amt_mod),
      .cin      (carry_in),
      .res      (core_res),
      .cout     (core_cout),
      .err      (core_err)
   );

   opsh_outstage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out (
      .clk    (clk),
      .rst_n  (rst_n),
      .res_d  (core_res),
      .cout_d (core_cout),
      .err_d  (core_err),
      .res_q  (data_out),
      .cout_q (carry_out),
      .err_q  (kind_err)
   );

   // Checks on the combinational core, relating top-level inputs to core outputs.
   p_zero_amt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (amount_in[SHAMT_W-1:0] == '0 && kind_in <= 3'd3)
      |-> (core_res == data_in && core_cout == carry_in));

   p_lsl_big_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_in == 3'd0 && amount_in[SHAMT_W-1:0] > SHAMT_W'(WIDTH))
      |-> (core_res == '0 && !core_cout));

   p_lsr_big_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_in == 3'd1 && amount_in[SHAMT_W-1:0] > SHAMT_W'(WIDTH))
      |-> (core_res == '0 && !core_cout));

   p_asr_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_in == 3'd2 && amount_in[SHAMT_W-1:0] >= SHAMT_W'(WIDTH))
      |-> (core_res == {WIDTH{data_in[WIDTH-1]}} && core_cout == data_in[WIDTH-1]));

   p_rrx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_in == 3'd4)
      |-> (core_res[WIDTH-1] == carry_in && core_cout == data_in[0]
           && core_res[WIDTH-2:0] == data_in[WIDTH-1:1]));

   p_bad_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_in > 3'd4) |-> (core_err && core_res == data_in && core_cout == carry_in));

   p_good_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (kind_in <= 3'd4) |-> !core_err);
endmodule

// File: tb/opsh_shifter_tb.sv
module opsh_shifter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] data_in = '0;
   logic [2:0]  kind_in = '0;
   logic [31:0] amount_in = '0;
   logic        carry_in = 1'b0;
   logic [31:0] data_out;
   logic        carry_out;
   logic        kind_err;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #2 clk = ~clk;

   opsh_shifter u_dut (
      .clk(clk), .rst_n(rst_n), .data_in(data_in), .kind_in(kind_in),
      .amount_in(amount_in), .carry_in(carry_in),
      .data_out(data_out), .carry_out(carry_out), .kind_err(kind_err)
   );

   logic [31:0] patterns [6] = '{32'h0000_0001, 32'h8000_0000, 32'hA5A5_5A5A,
                                 32'h7FFF_FFFE, 32'hFFFF_FFFF, 32'h1234_8765};

   // Model written bit by bit from the requirements.
   task automatic model(input logic [31:0] a, input logic [2:0] k,
                        input logic [31:0] amt, input logic ci,
                        output logic [31:0] r, output logic co, output logic e);
      int n;
      int m;
      n = int'(amt[7:0]);
      r = a; co = ci; e = 1'b0;
      if (k > 3'd4) begin
         e = 1'b1;
      end else if (k == 3'd4) begin
         for (int i = 0; i < 31; i++) r[i] = a[i+1];
         r[31] = ci; co = a[0];
      end else if (n != 0) begin
         case (k)
            3'd0: begin
               for (int i = 0; i < 32; i++) r[i] = (i >= n) ? a[i-n] : 1'b0;
               co = (n <= 32) ? a[32-n] : 1'b0;
            end
            3'd1: begin
               for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : 1'b0;
               co = (n <= 32) ? a[n-1] : 1'b0;
            end
            3'd2: begin
               for (int i = 0; i < 32; i++) r[i] = (i + n < 32) ? a[i+n] : a[31];
               co = (n <= 32) ? a[n-1] : a[31];
            end
            default: begin
               m = n % 32;
               for (int i = 0; i < 32; i++) r[i] = a[(i + m) % 32];
               co = r[31];
            end
         endcase
      end
   endtask

   task automatic check(input string req, input logic [31:0] a, input logic [2:0] k,
                        input logic [31:0] amt, input logic ci);
      logic [31:0] er;
      logic ec, ee;
      model(a, k, amt, ci, er, ec, ee);
      @(negedge clk);
      data_in = a; kind_in = k; amount_in = amt; carry_in = ci;
      @(posedge clk);
      #1;
      n_tests++;
      if (data_out !== er || carry_out !== ec || kind_err !== ee) begin
         n_fail++;
         $display("FAIL %s kind=%0d amt=%0h in=%h cin=%b: got res=%h c=%b e=%b exp res=%h c=%b e=%b",
                  req, k, amt, a, ci, data_out, carry_out, kind_err, er, ec, ee);
      end
   endtask

   task automatic t_reset();
      data_in = 32'hFFFF_FFFF; kind_in = 3'd6; carry_in = 1'b1;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      n_tests++;
      if (data_out !== '0 || carry_out !== 1'b0 || kind_err !== 1'b0) begin
         n_fail++;
         $display("FAIL R12 reset: got res=%h c=%b e=%b exp 0 0 0", data_out, carry_out, kind_err);
      end
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic t_kind_sweep(input string req, input logic [2:0] k);
      foreach (patterns[p]) begin
         for (int n = 1; n <= 40; n++) check(req, patterns[p], k, 32'(n), p[0]);
         check(req, patterns[p], k, 32'd255, ~p[0]);
      end
   endtask

   task automatic t_zero();
      for (int k = 0; k < 4; k++)
         foreach (patterns[p]) begin
            check("R3", patterns[p], 3'(k), 32'd0, 1'b1);
            check("R3", patterns[p], 3'(k), 32'd0, 1'b0);
         end
   endtask

   task automatic t_boundaries();
      check("R1", 32'h0000_0001, 3'd0, 32'd32, 1'b0);
      check("R2", 32'hFFFF_FFFF, 3'd0, 32'd33, 1'b1);
      check("R4", 32'h8000_0000, 3'd1, 32'd32, 1'b0);
      check("R5", 32'hFFFF_FFFF, 3'd1, 32'd33, 1'b1);
      check("R6", 32'h8000_0000, 3'd2, 32'd32, 1'b0);
      check("R7", 32'h8000_0001, 3'd2, 32'd200, 1'b0);
      check("R8", 32'h8000_0001, 3'd3, 32'd64, 1'b0);
      check("R8", 32'h0000_0001, 3'd3, 32'd96, 1'b1);
   endtask

   task automatic t_rrx();
      foreach (patterns[p]) begin
         check("R9", patterns[p], 3'd4, 32'd0, 1'b1);
         check("R9", patterns[p], 3'd4, 32'd7, 1'b0);
         check("R9", patterns[p], 3'd4, 32'hFFFF_FFFF, 1'b1);
      end
   endtask

   task automatic t_high_bits();
      for (int k = 0; k < 5; k++) begin
         check("R10", 32'hC3C3_1E1E, 3'(k), 32'hFFFF_FF00, 1'b1);
         check("R10", 32'hC3C3_1E1E, 3'(k), 32'h0001_0005, 1'b0);
         check("R10", 32'hC3C3_1E1E, 3'(k), 32'h8000_0021, 1'b0);
      end
   endtask

   task automatic t_bad_codes();
      for (int k = 5; k < 8; k++) begin
         check("R11", 32'h1357_9BDF, 3'(k), 32'd4, 1'b1);
         check("R11", 32'hFEDC_BA98, 3'(k), 32'd0, 1'b0);
      end
   endtask

   initial begin
      int cycles;
      cycles = 0;
      while (!done && cycles < 150000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not complete, got timeout exp completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_kind_sweep("R1", 3'd0);
      t_kind_sweep("R4", 3'd1);
      t_kind_sweep("R6", 3'd2);
      t_kind_sweep("R8", 3'd3);
      t_zero();
      t_boundaries();
      t_rrx();
      t_high_bits();
      t_bad_codes();
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule